// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block adds two unsigned operands of `WIDTH` bits and a carry input. It produces a `WIDTH`-bit sum and a carry output, and it has no clock or state. Each bit position first forms a local generate term (both operand bits set) and a local propagate term (the operand bits differ). A prefix network of carry-combining cells then reduces these terms so that each position `i` holds the generate and propagate of the whole span from bit 0 up to `i`. The carry into every position follows from those span values and the carry input, so all carries are ready after a number of cell levels that grows with the logarithm of the width.

The combining cell takes a lower-span pair and an upper-span pair. Its generate output is the upper generate ORed with the lower generate ANDed with the upper propagate. Its propagate output is the AND of both propagates. The operation is associative, so the network may group spans freely and spans may overlap. It is not commutative, so every cell wires its lower input to the less significant span. The parameter `TOPOLOGY` picks one of three wirings, and each wiring trades cell count against depth:

- recursive halving: few levels, with wide fan-out;
- up-sweep/down-sweep: fewest cells, about twice the depth;
- full doubling: few levels, with the most cells.

The span pairs are also driven out on two vector outputs for observation.

Top module: `pp_adder`

## Requirements
- R1: For every operand pair and carry input, `{cout, sum}` equals the (`WIDTH`+1)-bit value `a + b + cin`, for each of the three topologies.
- R2: Bit `i` of `grp_p` is 1 exactly when `a[j] != b[j]` for every `j` in 0..i. Bit `i` of `grp_g` is the carry that leaves bit `i` when bits 0..i are added with a zero carry input.
- R3: No position ever has `grp_g[i]` and `grp_p[i]` both set.
- R4: When every bit position propagates (`a ^ b` all ones), every sum bit equals `~cin` and `cout` equals `cin`.
- R5: When both operands are zero, `sum` equals `cin` zero-extended and `cout` is 0.
- R6: The recursive-halving wiring (`TOPOLOGY` = `PP_TOPO_HALVING`) builds (k/2)·log2(k) cells in log2(k) levels, for k = 8, 16 and 32.
- R7: The up-sweep/down-sweep wiring (`PP_TOPO_SWEEP`) builds 2k − 2 − log2(k) cells in 2·log2(k) − 1 levels, for k = 8, 16 and 32.
- R8: The full-doubling wiring (`PP_TOPO_DOUBLING`) builds k·log2(k) − k + 1 cells in log2(k) levels, for k = 8, 16 and 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |
| grp_g | output | WIDTH | Span generate, bits 0..i, for each position i |
| grp_p | output | WIDTH | Span propagate, bits 0..i, for each position i |

## Verification
The bench builds the adder three times at a width of 16, once with each `TOPOLOGY` value. All three instances receive the same vectors, so a wrong partner in any one wiring appears as a disagreement with the arithmetic model. The vectors cover zeros, all ones, alternating patterns, full-propagate words and random words, each with both carry-input values. At 16 bits, every span length up to the full word occurs at the outputs. The cell and level counts that the generate loops realize come from the shared package and are compared with the closed-form costs at widths 8, 16 and 32.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        PP_TOPO_HALVING  = 2'd0,
        PP_TOPO_SWEEP    = 2'd1,
        PP_TOPO_DOUBLING = 2'd2
    } pp_topo_e;

    function automatic int pp_log2(input int k);
        int r;
        r = 0;
        while ((1 << r) < k) r++;
        return r;
    endfunction

    // Number of cell levels the chosen wiring walks through.
    function automatic int pp_levels(input pp_topo_e topo, input int k);
        int lg;
        lg = pp_log2(k);
        if (topo == PP_TOPO_SWEEP) return 2 * lg - 1;
        return lg;
    endfunction

    // Index of the lower span combined into position i at level lvl,
    // or -1 when position i only passes its value on.
    function automatic int pp_partner(input pp_topo_e topo, input int k,
                                      input int lvl, input int i);
        int lg;
        int d;
        lg = pp_log2(k);
        case (topo)
            PP_TOPO_HALVING: begin
                d = 1 << lvl;
                if ((i & d) != 0) return ((i >> lvl) << lvl) - 1;
                return -1;
            end
            PP_TOPO_SWEEP: begin
                if (lvl < lg) begin
                    d = 1 << lvl;
                    if (((i + 1) % (2 * d)) == 0) return i - d;
                    return -1;
                end
                d = 1 << (2 * lg - 2 - lvl);
                if ((((i + 1) % (2 * d)) == d) && ((i + 1) > 2 * d)) return i - d;
                return -1;
            end
            default: begin
                d = 1 << lvl;
                if (i >= d) return i - d;
                return -1;
            end
        endcase
    endfunction

    // Cells actually placed by the generate rules.
    function automatic int pp_cell_count(input pp_topo_e topo, input int k);
        int n;
        n = 0;
        for (int l = 0; l < pp_levels(topo, k); l++)
            for (int i = 0; i < k; i++)
                if (pp_partner(topo, k, l, i) >= 0) n++;
        return n;
    endfunction

    // Levels that hold at least one cell.
    function automatic int pp_depth(input pp_topo_e topo, input int k);
        int n;
        bit used;
        n = 0;
        for (int l = 0; l < pp_levels(topo, k); l++) begin
            used = 1'b0;
            for (int i = 0; i < k; i++)
                if (pp_partner(topo, k, l, i) >= 0) used = 1'b1;
            if (used) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/pp_pg_gen.sv
module pp_pg_gen #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] bit_g,
    output logic [WIDTH-1:0] bit_p
);

    always_comb begin
        bit_g = a & b;
        bit_p = a ^ b;
    end

endmodule

// File: rtl/pp_carry_cell.sv
module pp_carry_cell (
    input  logic lo_g,
    input  logic lo_p,
    input  logic hi_g,
    input  logic hi_p,
    output logic g,
    output logic p
);

    // Lower span must enter on the lo_* side: the operation is not commutative.
    always_comb begin
        g = hi_g | (lo_g & hi_p);
        p = hi_p & lo_p;
    end

endmodule

// File: rtl/pp_prefix_net.sv
module pp_prefix_net
    import pp_pkg::*;
#(
    parameter int       WIDTH    = 16,
    parameter pp_topo_e TOPOLOGY = PP_TOPO_DOUBLING
) (
    input  logic [WIDTH-1:0] bit_g,
    input  logic [WIDTH-1:0] bit_p,
    output logic [WIDTH-1:0] grp_g,
    output logic [WIDTH-1:0] grp_p
);

    localparam int NLEV = pp_levels(TOPOLOGY, WIDTH);

    for (genvar l = 0; l <= NLEV; l++) begin : g_lvl
        logic [WIDTH-1:0] g;
        logic [WIDTH-1:0] p;
        if (l == 0) begin : g_leaf
            assign g = bit_g;
            assign p = bit_p;
        end else begin : g_node
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                localparam int J = pp_partner(TOPOLOGY, WIDTH, l - 1, i);
                if (J >= 0) begin : g_cell
                    pp_carry_cell u_cell (
                        .lo_g (g_lvl[l-1].g[J]),
                        .lo_p (g_lvl[l-1].p[J]),
                        .hi_g (g_lvl[l-1].g[i]),
                        .hi_p (g_lvl[l-1].p[i]),
                        .g    (g[i]),
                        .p    (p[i])
                    );
                end else begin : g_pass
                    assign g[i] = g_lvl[l-1].g[i];
                    assign p[i] = g_lvl[l-1].p[i];
                end
            end
        end
    end

    assign grp_g = g_lvl[NLEV].g;
    assign grp_p = g_lvl[NLEV].p;

    // R3: a span cannot both generate and propagate
    always_comb begin
        p_span_excl_r3: assert ((grp_g & grp_p) == '0)
            else $error("span generate and propagate both set");
    end

    // R2: whole-word propagate agrees with the per-bit terms
    always_comb begin
        p_top_prop_r2: assert (grp_p[WIDTH-1] == (&bit_p))
            else $error("top span propagate mismatch");
    end

endmodule

// File: rtl/pp_sum_stage.sv
module pp_sum_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] bit_p,
    input  logic [WIDTH-1:0] grp_g,
    input  logic [WIDTH-1:0] grp_p,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] carry;

    always_comb begin
        carry[0] = cin;
        for (int i = 0; i < WIDTH; i++)
            carry[i+1] = grp_g[i] | (grp_p[i] & cin);
        sum  = bit_p ^ carry[WIDTH-1:0];
        cout = carry[WIDTH];
    end

endmodule

// File: rtl/pp_adder.sv
module pp_adder
    import pp_pkg::*;
#(
    parameter int       WIDTH    = 16,
    parameter pp_topo_e TOPOLOGY = PP_TOPO_DOUBLING
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic [WIDTH-1:0] grp_g,
    output logic [WIDTH-1:0] grp_p
);

    localparam int CELL_COUNT = pp_cell_count(TOPOLOGY, WIDTH);
    localparam int DEPTH      = pp_depth(TOPOLOGY, WIDTH);

    logic [WIDTH-1:0] bit_g;
    logic [WIDTH-1:0] bit_p;

    pp_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .a     (a),
        .b     (b),
        .bit_g (bit_g),
        .bit_p (bit_p)
    );

    pp_prefix_net #(.WIDTH(WIDTH), .TOPOLOGY(TOPOLOGY)) u_net (
        .bit_g (bit_g),
        .bit_p (bit_p),
        .grp_g (grp_g),
        .grp_p (grp_p)
    );

    pp_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .bit_p (bit_p),
        .grp_g (grp_g),
        .grp_p (grp_p),
        .cin   (cin),
        .sum   (sum),
        .cout  (cout)
    );

    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    // R1: arithmetic result
    always_comb begin
        p_sum_value_r1: assert ({cout, sum} == ref_total)
            else $error("sum mismatch");
    end

    // R4: full-propagate word passes the carry straight through
    always_comb begin
        if ((a ^ b) == '1) begin
            p_all_prop_r4: assert ((sum == {WIDTH{~cin}}) && (cout == cin))
                else $error("full-propagate result wrong");
        end
    end

    // R5: zero operands
    always_comb begin
        if ((a == '0) && (b == '0)) begin
            p_zero_ops_r5: assert ((sum == {{(WIDTH-1){1'b0}}, cin}) && !cout)
                else $error("zero-operand result wrong");
        end
    end

endmodule

// File: tb/test_pp_adder.sv
module test_pp_adder;
    import pp_pkg::*;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;

    logic [W-1:0] s_sum [3];
    logic         s_cout [3];
    logic [W-1:0] s_g [3];
    logic [W-1:0] s_p [3];

    pp_adder #(.WIDTH(W), .TOPOLOGY(PP_TOPO_HALVING)) i_pp_adder_half (
        .a(a), .b(b), .cin(cin), .sum(s_sum[0]), .cout(s_cout[0]),
        .grp_g(s_g[0]), .grp_p(s_p[0]));
    pp_adder #(.WIDTH(W), .TOPOLOGY(PP_TOPO_SWEEP)) i_pp_adder_sweep (
        .a(a), .b(b), .cin(cin), .sum(s_sum[1]), .cout(s_cout[1]),
        .grp_g(s_g[1]), .grp_p(s_p[1]));
    pp_adder #(.WIDTH(W), .TOPOLOGY(PP_TOPO_DOUBLING)) i_pp_adder_dbl (
        .a(a), .b(b), .cin(cin), .sum(s_sum[2]), .cout(s_cout[2]),
        .grp_g(s_g[2]), .grp_p(s_p[2]));

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        logic [W:0]   total;
        logic [W-1:0] g;
        logic [W-1:0] p;
    } item_t;

    item_t sb[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit reported = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
        item_t it;
        logic gg, pp;
        @(posedge clk);
        #1;
        a = va; b = vb; cin = vc;
        it.a = va; it.b = vb; it.cin = vc;
        it.total = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        gg = 1'b0; pp = 1'b1;
        for (int i = 0; i < W; i++) begin
            gg = (va[i] & vb[i]) | (gg & (va[i] ^ vb[i]));
            pp = pp & (va[i] ^ vb[i]);
            it.g[i] = gg;
            it.p[i] = pp;
        end
        sb.push_back(it);
    endtask

    // Monitor: compares at the falling edge after each drive
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                for (int t = 0; t < 3; t++) begin
                    check({s_cout[t], s_sum[t]} == it.total, $sformatf("R1 topo%0d", t),
                          64'({s_cout[t], s_sum[t]}), 64'(it.total));
                    check(s_g[t] == it.g, $sformatf("R2 gen topo%0d", t), 64'(s_g[t]), 64'(it.g));
                    check(s_p[t] == it.p, $sformatf("R2 prop topo%0d", t), 64'(s_p[t]), 64'(it.p));
                    check((s_g[t] & s_p[t]) == '0, $sformatf("R3 topo%0d", t),
                          64'(s_g[t] & s_p[t]), 64'd0);
                    if ((it.a ^ it.b) == '1)
                        check((s_sum[t] == {W{~it.cin}}) && (s_cout[t] == it.cin),
                              $sformatf("R4 topo%0d", t), 64'({s_cout[t], s_sum[t]}),
                              64'({it.cin, {W{~it.cin}}}));
                    if ((it.a == '0) && (it.b == '0))
                        check((s_sum[t] == W'(it.cin)) && !s_cout[t],
                              $sformatf("R5 topo%0d", t), 64'({s_cout[t], s_sum[t]}),
                              64'(it.cin));
                end
            end
        end
    end

    task automatic check_cost(input int k);
        int lg;
        lg = pp_log2(k);
        check(pp_cell_count(PP_TOPO_HALVING, k) == (k / 2) * lg, $sformatf("R6 cells k=%0d", k),
              64'(pp_cell_count(PP_TOPO_HALVING, k)), 64'((k / 2) * lg));
        check(pp_depth(PP_TOPO_HALVING, k) == lg, $sformatf("R6 depth k=%0d", k),
              64'(pp_depth(PP_TOPO_HALVING, k)), 64'(lg));
        check(pp_cell_count(PP_TOPO_SWEEP, k) == 2 * k - 2 - lg, $sformatf("R7 cells k=%0d", k),
              64'(pp_cell_count(PP_TOPO_SWEEP, k)), 64'(2 * k - 2 - lg));
        check(pp_depth(PP_TOPO_SWEEP, k) == 2 * lg - 1, $sformatf("R7 depth k=%0d", k),
              64'(pp_depth(PP_TOPO_SWEEP, k)), 64'(2 * lg - 1));
        check(pp_cell_count(PP_TOPO_DOUBLING, k) == k * lg - k + 1, $sformatf("R8 cells k=%0d", k),
              64'(pp_cell_count(PP_TOPO_DOUBLING, k)), 64'(k * lg - k + 1));
        check(pp_depth(PP_TOPO_DOUBLING, k) == lg, $sformatf("R8 depth k=%0d", k),
              64'(pp_depth(PP_TOPO_DOUBLING, k)), 64'(lg));
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
    endtask

    initial begin
        // reset state: zero inputs give zero outputs (R5)
        drive('0, '0, 1'b0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        check_cost(8);
        check_cost(16);
        check_cost(32);
        for (int c = 0; c < 2; c++) begin
            drive('0, '0, c[0]);                   // R5
            drive('1, '1, c[0]);                   // R1 all ones
            drive('1, '0, c[0]);                   // R4
            drive('0, '1, c[0]);                   // R4
            drive(16'haaaa, 16'h5555, c[0]);       // R4 alternating
            drive(16'haaaa, 16'haaaa, c[0]);
            drive(16'h5555, 16'h5555, c[0]);
            drive(16'h0001, 16'hffff, c[0]);
            drive(16'h8000, 16'h8000, c[0]);
        end
        for (int n = 0; n < 400; n++)
            drive(W'($urandom), W'($urandom), 1'($urandom));
        repeat (3) @(posedge clk);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
            $finish;
        end
    end

endmodule